// File: doc/BRIEF.md
# Wide Register Dword Access Bridge

This bridge connects a 32-bit host register bus to a bank of 128-bit registers. Each wide register occupies four consecutive 32-bit words. Host writes to a wide register are gathered in a collector. The register is updated in one step only after every word has arrived, so a partly written value never reaches the bank.

Host reads of a wide register load the whole 128-bit value into a read snapshot. The later words of that read come from the snapshot, so the host sees one consistent value.

Two doorbell registers in each page are write-only. A write to their top word always commits, and any lower words the collector does not hold are sent as zero. A write to the timer-command word in page 0 drops whatever the collector holds. Small 32-bit registers bypass both the snapshot and the collector.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, `rvalid_o` and `commit_o` are low, and every wide and plain register reads as zero.
- R2: Address decoding works as follows:
  - The page number is `addr_i[13]`, and the offset within the page is `addr_i[12:0]`.
  - Wide registers 0 to 3 sit at offsets 0x00, 0x10, 0x20 and 0x30. The word index is `addr_i[3:2]`.
  - Doorbells sit at offsets 0x830 and 0xA10, plain words at 0x100 to 0x10C, and the timer command at 0x420.
  - `commit_idx_o` is {page, slot}. Slots 0 to 3 are the wide registers, slot 4 is 0x830 and slot 5 is 0xA10.
  - An access with `addr_i[1:0]` not equal to zero is ignored.
- R3: A read of word 0 of a wide register loads a snapshot and returns the live word. So does a read of any word of a register other than the one currently held in the snapshot.
- R4: A read of word 1, 2 or 3 of the register held in the snapshot returns the snapshot word, even if the register was committed since the snapshot was taken.
- R5: Writes to a wide register commit only once all four words have been written, in any order. `commit_o` then pulses for one cycle, on the cycle after the completing write, with the index and the data. The bank holds the new value from the following cycle.
- R6: A wide-register write to a register other than the one in the collector restarts the collector with that word, and earlier partial words are dropped.
- R7: A doorbell top-word write (offset +12) always commits. Lower words come from the collector only if it holds that same doorbell; all other lower words are zero. The collector is then empty.
- R8: A doorbell lower-word write is discarded while the collector holds partial words of another register, and the collector state is unchanged.
- R9: A write to the timer command in page 0 empties the collector. The same offset in page 1 has no effect.
- R10: Plain 32-bit words are read and written directly. They leave the collector and the snapshot untouched.
- R11: Each read request gives a one-cycle `rvalid_o` pulse on the following cycle. Doorbell and unmapped reads return zero, and writes give no `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Byte address: {page, offset} |
| wdata_i | input | 32 | Write word |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read word |
| commit_o | output | 1 | One-cycle wide-register commit strobe |
| commit_idx_o | output | 4 | Committed register {page, slot} |
| commit_data_o | output | 128 | Committed 128-bit value |

## Verification
The bench commits a register between two word reads of it. A design that reads live data instead of the snapshot would return the new words. It then reads a different register in between, which must force a reload; a design that keeps the stale snapshot would fail this. It sends partial writes that must produce no commit:
- an interrupted assembly,
- a timer-command clear,
- a misaligned access.

A collector that commits early or keeps dropped words would raise an unexpected strobe. Doorbell cases cover a bare top-word write, a gathered-and-zero-filled write, and a discarded lower word. A design that merged or lost data in those cases would put the wrong 128-bit value on the commit port.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int OFS_W = 13;
  localparam logic [OFS_W-1:0] DB_A_OFS   = 13'h830;
  localparam logic [OFS_W-1:0] DB_B_OFS   = 13'hA10;
  localparam logic [OFS_W-1:0] TMR_OFS    = 13'h420;
  localparam logic [OFS_W-1:0] PLAIN_BASE = 13'h100;

  typedef enum logic [2:0] {
    K_NONE, K_WIDE, K_DBELL, K_PLAIN, K_TIMER
  } kind_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode import wrb_pkg::*; #(
  parameter  int PAGE_W  = 1,
  parameter  int WIDE_N  = 4,
  parameter  int PLAIN_N = 4,
  localparam int ADDR_W  = PAGE_W + OFS_W,
  localparam int SLOT_W  = $clog2(WIDE_N + 2),
  localparam int IDX_W   = PAGE_W + SLOT_W,
  localparam int PIDX_W  = PAGE_W + $clog2(PLAIN_N)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output kind_e             kind_o,
  output logic [1:0]        dw_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PIDX_W-1:0] pidx_o
);
  localparam int PL_W = $clog2(PLAIN_N);

  logic [OFS_W-1:0]  ofs;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  base;

  always_comb begin
    ofs    = addr_i[OFS_W-1:0];
    page   = addr_i[ADDR_W-1:OFS_W];
    base   = {ofs[OFS_W-1:4], 4'h0};
    dw_o   = addr_i[3:2];
    kind_o = K_NONE;
    idx_o  = '0;
    pidx_o = '0;
    if (addr_i[1:0] != 2'b00) begin
      kind_o = K_NONE;
    end else if (base == DB_A_OFS) begin
      kind_o = K_DBELL;
      idx_o  = {page, SLOT_W'(WIDE_N)};
    end else if (base == DB_B_OFS) begin
      kind_o = K_DBELL;
      idx_o  = {page, SLOT_W'(WIDE_N + 1)};
    end else if (ofs < OFS_W'(WIDE_N * 16)) begin
      kind_o = K_WIDE;
      idx_o  = {page, ofs[4 +: SLOT_W]};
    end else if (ofs == TMR_OFS) begin
      kind_o = (page == '0) ? K_TIMER : K_NONE;
    end else if (ofs >= PLAIN_BASE && ofs < PLAIN_BASE + OFS_W'(PLAIN_N * 4)) begin
      kind_o = K_PLAIN;
      pidx_o = {page, ofs[2 +: PL_W]};
    end
  end
endmodule

// File: rtl/wrb_collector.sv
module wrb_collector import wrb_pkg::*; #(
  parameter  int PAGE_W = 1,
  parameter  int WIDE_N = 4,
  localparam int SLOT_W = $clog2(WIDE_N + 2),
  localparam int IDX_W  = PAGE_W + SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  kind_e            kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       dw_i,
  input  logic [31:0]      wdata_i,
  output logic             commit_o,
  output logic [IDX_W-1:0] commit_idx_o,
  output logic [127:0]     commit_data_o
);
  logic [3:0]       mask_q, mask_n;
  logic [IDX_W-1:0] cidx_q, cidx_n;
  logic [127:0]     cdata_q, cdata_n, fdata;
  logic             fire, hit, busy_other;

  always_comb begin
    mask_n     = mask_q;
    cidx_n     = cidx_q;
    cdata_n    = cdata_q;
    fdata      = cdata_q;
    fire       = 1'b0;
    hit        = (mask_q != 4'h0) && (cidx_q == idx_i);
    busy_other = (mask_q != 4'h0) && !hit;
    if (wr_i) begin
      unique case (kind_i)
        K_WIDE: begin
          if (busy_other) mask_n = 4'h0;  // restart, drop partial words
          cidx_n                    = idx_i;
          mask_n[dw_i]              = 1'b1;
          cdata_n[{dw_i, 5'd0} +: 32] = wdata_i;
          if (mask_n == 4'hF) begin
            fire   = 1'b1;
            fdata  = cdata_n;
            mask_n = 4'h0;
          end
        end
        K_DBELL: begin
          if (dw_i == 2'd3) begin
            fire = 1'b1;
            for (int k = 0; k < 3; k++)
              fdata[k*32 +: 32] = (hit && mask_q[k]) ? cdata_q[k*32 +: 32] : 32'h0;
            fdata[127:96] = wdata_i;
            mask_n        = 4'h0;
          end else if (!busy_other) begin
            cidx_n                      = idx_i;
            mask_n[dw_i]                = 1'b1;
            cdata_n[{dw_i, 5'd0} +: 32] = wdata_i;
          end
        end
        K_TIMER: mask_n = 4'h0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q        <= 4'h0;
      cidx_q        <= '0;
      cdata_q       <= '0;
      commit_o      <= 1'b0;
      commit_idx_o  <= '0;
      commit_data_o <= '0;
    end else begin
      mask_q   <= mask_n;
      cidx_q   <= cidx_n;
      cdata_q  <= cdata_n;
      commit_o <= fire;
      if (fire) begin
        commit_idx_o  <= idx_i;
        commit_data_o <= fdata;
      end
    end
  end

  a_r5_full_before_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && commit_idx_o[SLOT_W-1:0] < SLOT_W'(WIDE_N)) |-> $countones($past(mask_q)) == 3);
  a_r5_mask_empty_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> mask_q == 4'h0);
  a_r7_doorbell_top_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_DBELL && dw_i == 2'd3) |=> commit_o && commit_idx_o == $past(idx_i));
  a_r8_discard_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_DBELL && dw_i != 2'd3 && busy_other)
      |=> $stable(mask_q) && $stable(cidx_q) && !commit_o);
  a_r9_timer_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_TIMER) |=> mask_q == 4'h0);
endmodule

// File: rtl/wrb_read_latch.sv
module wrb_read_latch #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       dw_i,
  input  logic [127:0]     live_i,
  output logic [31:0]      dword_o
);
  logic             lat_v_q;
  logic [IDX_W-1:0] lat_idx_q;
  logic [127:0]     lat_data_q;
  logic             use_lat;

  assign use_lat = (dw_i != 2'd0) && lat_v_q && (lat_idx_q == idx_i);
  assign dword_o = use_lat ? lat_data_q[{dw_i, 5'd0} +: 32] : live_i[{dw_i, 5'd0} +: 32];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_v_q    <= 1'b0;
      lat_idx_q  <= '0;
      lat_data_q <= '0;
    end else if (rd_i && !use_lat) begin
      lat_v_q    <= 1'b1;
      lat_idx_q  <= idx_i;
      lat_data_q <= live_i;
    end
  end

  a_r3_capture_on_word0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && dw_i == 2'd0) |=> lat_v_q && lat_idx_q == $past(idx_i));
  a_r4_snapshot_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && dw_i != 2'd0 && lat_v_q && lat_idx_q == idx_i) |=> $stable(lat_data_q));
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge import wrb_pkg::*; #(
  parameter  int PAGE_W  = 1,
  parameter  int WIDE_N  = 4,
  parameter  int PLAIN_N = 4,
  localparam int ADDR_W  = PAGE_W + OFS_W,
  localparam int SLOT_W  = $clog2(WIDE_N + 2),
  localparam int IDX_W   = PAGE_W + SLOT_W,
  localparam int PIDX_W  = PAGE_W + $clog2(PLAIN_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_idx_o,
  output logic [127:0]      commit_data_o
);
  localparam int BANK_D  = 2 ** IDX_W;
  localparam int PLAIN_D = 2 ** PIDX_W;

  kind_e             kind;
  logic [1:0]        dw;
  logic [IDX_W-1:0]  idx;
  logic [PIDX_W-1:0] pidx;
  logic [31:0]       lat_dword;
  logic [127:0]      bank_q [BANK_D];
  logic [31:0]       plain_q [PLAIN_D];
  logic              rd_req;

  assign rd_req = req_i && !we_i;

  wrb_decode #(.PAGE_W(PAGE_W), .WIDE_N(WIDE_N), .PLAIN_N(PLAIN_N)) u_dec (
    .addr_i(addr_i), .kind_o(kind), .dw_o(dw), .idx_o(idx), .pidx_o(pidx)
  );

  wrb_collector #(.PAGE_W(PAGE_W), .WIDE_N(WIDE_N)) u_col (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(req_i && we_i), .kind_i(kind),
    .idx_i(idx), .dw_i(dw), .wdata_i(wdata_i), .commit_o(commit_o),
    .commit_idx_o(commit_idx_o), .commit_data_o(commit_data_o)
  );

  wrb_read_latch #(.IDX_W(IDX_W)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_req && kind == K_WIDE),
    .idx_i(idx), .dw_i(dw), .live_i(bank_q[idx]), .dword_o(lat_dword)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BANK_D; i++) bank_q[i] <= '0;
    end else if (commit_o && commit_idx_o[SLOT_W-1:0] < SLOT_W'(WIDE_N)) begin
      bank_q[commit_idx_o] <= commit_data_o;  // doorbells are not stored
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PLAIN_D; i++) plain_q[i] <= '0;
    end else if (req_i && we_i && kind == K_PLAIN) begin
      plain_q[pidx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) begin
        unique case (kind)
          K_WIDE:  rdata_o <= lat_dword;
          K_PLAIN: rdata_o <= plain_q[pidx];
          default: rdata_o <= '0;
        endcase
      end
    end
  end

  a_r11_rvalid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  a_r11_no_rvalid_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);
endmodule

// File: tb/wide_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module wide_reg_bridge_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [13:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic         rvalid, commit;
  logic [31:0]  rdata;
  logic [3:0]   cidx;
  logic [127:0] cdata;

  int checks = 0;
  int fails  = 0;

  logic [31:0]  rd_exp[$];
  string        rd_tag[$];
  logic [127:0] cm_exp[$];
  logic [3:0]   cm_idx[$];
  string        cm_tag[$];

  always #2.5 clk = ~clk;

  wide_reg_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .commit_o(commit),
    .commit_idx_o(cidx), .commit_data_o(cdata)
  );

  function automatic logic [13:0] wa(input int pg, input int rg, input int dw);
    return {pg[0], 13'(rg * 16 + dw * 4)};
  endfunction
  function automatic logic [13:0] pa(input int pg, input int ofs);
    return {pg[0], ofs[12:0]};
  endfunction

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [31:0] e, input string tag);
    rd_exp.push_back(e); rd_tag.push_back(tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic exp_commit(input logic [3:0] i, input logic [127:0] d, input string tag);
    cm_idx.push_back(i); cm_exp.push_back(d); cm_tag.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        checks++;
        if (rd_exp.size() == 0) begin
          fails++; $display("FAIL R11: unexpected rvalid, rdata=%h expected none", rdata);
        end else begin
          logic [31:0] e; string t;
          e = rd_exp.pop_front(); t = rd_tag.pop_front();
          if (rdata !== e) begin
            fails++; $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
          end
        end
      end
      if (commit) begin
        checks++;
        if (cm_exp.size() == 0) begin
          fails++; $display("FAIL R5: unexpected commit idx=%h data=%h expected none", cidx, cdata);
        end else begin
          logic [127:0] e; logic [3:0] i; string t;
          e = cm_exp.pop_front(); i = cm_idx.pop_front(); t = cm_tag.pop_front();
          if (cdata !== e || cidx !== i) begin
            fails++;
            $display("FAIL %s: commit idx=%h data=%h expected idx=%h data=%h", t, cidx, cdata, i, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rvalid !== 1'b0 || commit !== 1'b0) begin  // R1
      fails++; $display("FAIL R1: rvalid=%b commit=%b expected 0 0", rvalid, commit);
    end
    rst_n = 1'b1;
    rd(wa(0, 0, 0), 32'h0, "R1");
    rd(pa(0, 'h104), 32'h0, "R1");

    // R5 in-order assembly
    wr(wa(0, 0, 0), 32'hA0); wr(wa(0, 0, 1), 32'hA1); wr(wa(0, 0, 2), 32'hA2);
    exp_commit(4'h0, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, "R5");
    wr(wa(0, 0, 3), 32'hA3);
    for (int k = 0; k < 4; k++) rd(wa(0, 0, k), 32'hA0 + 32'(k), "R3");

    // R4 snapshot survives a commit; R5 out-of-order
    rd(wa(0, 0, 0), 32'hA0, "R3");
    wr(wa(0, 0, 3), 32'hB3); wr(wa(0, 0, 1), 32'hB1); wr(wa(0, 0, 0), 32'hB0);
    exp_commit(4'h0, {32'hB3, 32'hB2, 32'hB1, 32'hB0}, "R5");
    wr(wa(0, 0, 2), 32'hB2);
    rd(wa(0, 0, 1), 32'hA1, "R4");
    rd(wa(0, 0, 2), 32'hA2, "R4");
    rd(wa(0, 0, 0), 32'hB0, "R3");
    rd(wa(0, 0, 3), 32'hB3, "R4");

    // R3 other register recaptures
    rd(wa(0, 0, 0), 32'hB0, "R3");
    exp_commit(4'h0, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, "R5");
    for (int k = 0; k < 4; k++) wr(wa(0, 0, k), 32'hC0 + 32'(k));
    rd(wa(0, 1, 1), 32'h0, "R3");
    rd(wa(0, 0, 2), 32'hC2, "R3");

    // R6 restart drops partial words
    wr(wa(0, 2, 0), 32'hD0); wr(wa(0, 2, 1), 32'hD1);
    exp_commit(4'h3, {32'hE3, 32'hE2, 32'hE1, 32'hE0}, "R6");
    for (int k = 0; k < 4; k++) wr(wa(0, 3, k), 32'hE0 + 32'(k));
    wr(wa(0, 2, 2), 32'hF2); wr(wa(0, 2, 3), 32'hF3);  // no commit allowed
    wr(wa(0, 2, 0), 32'hF0);
    exp_commit(4'h2, {32'hF3, 32'hF2, 32'hF1, 32'hF0}, "R6");
    wr(wa(0, 2, 1), 32'hF1);
    rd(wa(0, 2, 1), 32'hF1, "R6");

    // R7 doorbells
    exp_commit(4'hC, {32'h1D, 96'h0}, "R7");
    wr(pa(1, 'h83C), 32'h1D);
    wr(pa(0, 'hA10), 32'h20); wr(pa(0, 'hA18), 32'h22);
    exp_commit(4'h5, {32'h23, 32'h22, 32'h0, 32'h20}, "R7");
    wr(pa(0, 'hA1C), 32'h23);
    rd(pa(0, 'h838), 32'h0, "R11");

    // R8 discarded doorbell lower word
    wr(wa(0, 1, 0), 32'h30);
    wr(pa(0, 'h834), 32'hBAD);
    wr(wa(0, 1, 1), 32'h31); wr(wa(0, 1, 2), 32'h32);
    exp_commit(4'h1, {32'h33, 32'h32, 32'h31, 32'h30}, "R8");
    wr(wa(0, 1, 3), 32'h33);

    // R9 timer clear in page 0 only
    wr(wa(0, 0, 0), 32'h40); wr(wa(0, 0, 1), 32'h41);
    wr(pa(0, 'h420), 32'h1);
    wr(wa(0, 0, 2), 32'h52); wr(wa(0, 0, 3), 32'h53);  // no commit allowed
    wr(pa(1, 'h420), 32'h1);
    wr(wa(0, 0, 0), 32'h50);
    exp_commit(4'h0, {32'h53, 32'h52, 32'h51, 32'h50}, "R9");
    wr(wa(0, 0, 1), 32'h51);

    // R10 plain words bypass collector
    wr(pa(0, 'h104), 32'h60); wr(pa(1, 'h10C), 32'h61);
    wr(wa(0, 2, 0), 32'h70);
    wr(pa(0, 'h100), 32'h62);
    rd(pa(0, 'h104), 32'h60, "R10");
    rd(pa(1, 'h10C), 32'h61, "R10");
    rd(pa(0, 'h100), 32'h62, "R10");
    wr(wa(0, 2, 1), 32'h71); wr(wa(0, 2, 2), 32'h72);
    exp_commit(4'h2, {32'h73, 32'h72, 32'h71, 32'h70}, "R10");
    wr(wa(0, 2, 3), 32'h73);

    // R2 misaligned ignored, page separation
    wr(14'h0031, 32'hBAD);
    wr(wa(0, 3, 1), 32'h81); wr(wa(0, 3, 2), 32'h82); wr(wa(0, 3, 3), 32'h83);
    exp_commit(4'h3, {32'h83, 32'h82, 32'h81, 32'h80}, "R2");
    wr(wa(0, 3, 0), 32'h80);
    exp_commit(4'h8, {32'h93, 32'h92, 32'h91, 32'h90}, "R2");
    for (int k = 0; k < 4; k++) wr(wa(1, 0, k), 32'h90 + 32'(k));
    rd(wa(1, 0, 0), 32'h90, "R2");
    rd(wa(0, 0, 0), 32'h50, "R2");
    rd(pa(0, 'h200), 32'h0, "R11");

    repeat (5) @(negedge clk);
    checks++;
    if (rd_exp.size() != 0) begin
      fails++; $display("FAIL R11: %0d reads missing, expected 0", rd_exp.size());
    end
    checks++;
    if (cm_exp.size() != 0) begin
      fails++; $display("FAIL R5: %0d commits missing, expected 0", cm_exp.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule